// File: doc/BRIEF.md
# Serial-to-Parallel Deserializer with Bit-Slip

This block takes a one-bit serial stream and turns it into 8-bit parallel words. Every rising edge of the serial clock shifts one bit into a shift register. A counter divides the serial clock by the word width to make a parallel clock. At each word boundary the finished word is copied into an output register. The output word changes on the same serial edge where the parallel clock falls, so a downstream register clocked on the rising edge of the parallel clock always sees a settled word.

Word alignment is adjusted on request. A framing circuit downstream can raise the asynchronous sync input when it sees the wrong boundary. The input first passes through a two-flop synchronizer. A pulse that stays high for at least two consecutive serial cycles then counts as a qualified request.

A qualified request makes the divider hold its count for one extra serial cycle, in the low phase of the parallel clock. That word period therefore lasts nine serial cycles. The earliest of its nine bits falls out of the shift register, and the word boundary moves by one position. A small state machine tracks each request:
- SLIP_IDLE waits for a qualified request, then goes to SLIP_PEND.
- SLIP_PEND waits for the stall position of the counter. It stalls the counter there for exactly one cycle and goes to SLIP_REARM.
- SLIP_REARM waits for the qualified request to go low, then returns to SLIP_IDLE.

Top module: `deser_slip`

## Requirements
- R1: While synchronous reset is high, the parallel clock output is 0 and the parallel word output is all zeros.
- R2: With no slip, the parallel clock has a period of 8 serial cycles, made of 4 cycles low followed by 4 cycles high. After reset the first falling edge comes on the 8th serial rising edge after reset is released.
- R3: Each parallel word holds 8 consecutive serial bits. The earliest bit is on bit 7 and the latest on bit 0. The first word after reset holds the first 8 bits sampled after release.
- R4: The parallel word output changes only on the serial edge where the parallel clock falls.
- R5: A sync pulse that is high for only one serial cycle causes no slip. The word period stays 8 and no bit is dropped.
- R6: A sync pulse that is high for 2 or more serial cycles causes exactly one word period of 9 serial cycles, with the parallel clock held low for one extra cycle. The earliest of those 9 bits is dropped, and the word ends with the latest 8 bits.
- R7: Each qualified pulse gives exactly one slip, however long sync stays high. A new slip needs sync to go low and rise again.
- R8: The stretched word period starts no more than 16 serial cycles after the serial edge that follows the rise of sync.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ser | input | 1 | Serial bit clock |
| rst | input | 1 | Synchronous reset, active high |
| sdata_i | input | 1 | Serial data, sampled on rising edge of clk_ser |
| sync_i | input | 1 | Asynchronous realignment request, active high |
| pclk_o | output | 1 | Parallel clock, serial clock divided by 8 |
| pdata_o | output | 8 | Parallel word, earliest bit on bit 7 |

## Verification
The bench builds the block with WORD_W = 8 and SYNC_STAGES = 2. These are the default word width and the shortest synchronizer. With them, a nine-cycle stretched period can be clearly told apart from normal eight-cycle periods. The one-cycle and two-cycle sync pulses also sit exactly on either side of the qualification threshold. The short synchronizer keeps the slip latency well inside the 16-cycle bound. This lets the bench check that bound along with the bits dropped and the number of slips per pulse.

// File: rtl/deser_pkg.sv
package deser_pkg;
    typedef enum logic [1:0] {
        SLIP_IDLE  = 2'd0,
        SLIP_PEND  = 2'd1,
        SLIP_REARM = 2'd2
    } slip_state_t;
endpackage

// File: rtl/sync_qual.sv
module sync_qual #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sync_i,
    output logic qual_o
);
    logic [SYNC_STAGES-1:0] chain;
    logic                   held;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            held  <= 1'b0;
        end else begin
            chain <= {chain[SYNC_STAGES-2:0], sync_i};
            held  <= chain[SYNC_STAGES-1];
        end
    end

    assign qual_o = chain[SYNC_STAGES-1] & held;

    // R5: a request qualifies only after two consecutive high samples
    assert_short_pulse_ignored_R5: assert property (@(posedge clk) disable iff (rst)
        qual_o |-> ($past(sync_i, SYNC_STAGES) && $past(sync_i, SYNC_STAGES + 1)));
endmodule

// File: rtl/slip_fsm.sv
module slip_fsm
    import deser_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic qual_i,
    input  logic at_pos_i,
    output logic stall_o
);
    slip_state_t state, state_nxt;

    always_ff @(posedge clk) begin
        if (rst) state <= SLIP_IDLE;
        else     state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            SLIP_IDLE:  if (qual_i)   state_nxt = SLIP_PEND;
            SLIP_PEND:  if (at_pos_i) state_nxt = SLIP_REARM;
            SLIP_REARM: if (!qual_i)  state_nxt = SLIP_IDLE;
            default:                  state_nxt = SLIP_IDLE;
        endcase
    end

    always_comb begin
        stall_o = 1'b0;
        unique case (state)
            SLIP_PEND: stall_o = at_pos_i;
            default:   stall_o = 1'b0;
        endcase
    end

    // R7: one stall cycle per request
    assert_single_stall_R7: assert property (@(posedge clk) disable iff (rst)
        stall_o |=> !stall_o);
    // R7: a request still held high cannot re-arm the slip
    assert_hold_no_rearm_R7: assert property (@(posedge clk) disable iff (rst)
        (state == SLIP_REARM && qual_i) |=> (state == SLIP_REARM));
endmodule

// File: rtl/word_divider.sv
module word_divider #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sdata_i,
    input  logic              stall_i,
    output logic              at_pos_o,
    output logic              pclk_o,
    output logic [WORD_W-1:0] pdata_o
);
    localparam int CNT_W     = $clog2(WORD_W);
    localparam int HALF      = WORD_W / 2;
    localparam int LAST      = WORD_W - 1;
    localparam int STALL_POS = HALF - 1;

    logic [CNT_W-1:0]  cnt, cnt_nxt;
    logic [WORD_W-1:0] shreg;
    logic              pclk_q;

    always_comb begin
        if (stall_i)                    cnt_nxt = cnt;
        else if (cnt == CNT_W'(LAST))   cnt_nxt = '0;
        else                            cnt_nxt = cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            shreg   <= '0;
            pclk_q  <= 1'b0;
            pdata_o <= '0;
        end else begin
            cnt    <= cnt_nxt;
            shreg  <= {shreg[WORD_W-2:0], sdata_i};
            pclk_q <= (cnt_nxt >= CNT_W'(HALF));
            if (!stall_i && cnt == CNT_W'(LAST))
                pdata_o <= {shreg[WORD_W-2:0], sdata_i};
        end
    end

    assign at_pos_o = (cnt == CNT_W'(STALL_POS));
    assign pclk_o   = pclk_q;

    // R4: the word moves only together with a falling parallel clock
    assert_word_on_fall_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(pdata_o) |-> $fell(pclk_o));
    // R2: the low phase is never a single cycle
    assert_low_phase_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(pclk_o) |=> !pclk_o);
endmodule

// File: rtl/deser_slip.sv
module deser_slip #(
    parameter int WORD_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_ser,
    input  logic              rst,
    input  logic              sdata_i,
    input  logic              sync_i,
    output logic              pclk_o,
    output logic [WORD_W-1:0] pdata_o
);
    logic qual;
    logic at_pos;
    logic stall;

    sync_qual #(.SYNC_STAGES(SYNC_STAGES)) u_qual (
        .clk    (clk_ser),
        .rst    (rst),
        .sync_i (sync_i),
        .qual_o (qual)
    );

    slip_fsm u_fsm (
        .clk      (clk_ser),
        .rst      (rst),
        .qual_i   (qual),
        .at_pos_i (at_pos),
        .stall_o  (stall)
    );

    word_divider #(.WORD_W(WORD_W)) u_div (
        .clk      (clk_ser),
        .rst      (rst),
        .sdata_i  (sdata_i),
        .stall_i  (stall),
        .at_pos_o (at_pos),
        .pclk_o   (pclk_o),
        .pdata_o  (pdata_o)
    );

    // R1: reset holds both outputs low
    assert_reset_clear_R1: assert property (@(posedge clk_ser)
        $past(rst) |-> (!pclk_o && pdata_o == '0));
endmodule

// File: tb/test_deser_slip.sv
module test_deser_slip;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         sdata = 1'b0;
    logic         sync = 1'b0;
    logic         pclk;
    logic [W-1:0] pdata;

    always #4 clk = ~clk;

    deser_slip #(.WORD_W(W), .SYNC_STAGES(2)) i_deser_slip (
        .clk_ser (clk),
        .rst     (rst),
        .sdata_i (sdata),
        .sync_i  (sync),
        .pclk_o  (pclk),
        .pdata_o (pdata)
    );

    int       vectors = 0;
    int       errors = 0;
    bit       bitq[$];
    int       cyc = 0;
    int       last_fall = 0;
    int       slips = 0;
    int       rise_cyc = -1000;
    logic     prev_pclk = 1'b0;
    logic [W-1:0] prev_pdata = '0;
    logic [15:0]  lfsr = 16'hACE1;
    bit       done = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: pops expected bits from the scoreboard queue per finished word
    always @(posedge clk) begin
        int           per;
        logic [W-1:0] e;
        #2;
        if (rst) begin
            cyc = 0;
            last_fall = 0;
        end else begin
            cyc++;
            if (prev_pclk && !pclk) begin
                per = cyc - last_fall;
                if (per == W + 1) begin
                    slips++;
                    check(last_fall - rise_cyc <= 16, "R8 slip latency", last_fall - rise_cyc, 16);
                    if (bitq.size() > 0) void'(bitq.pop_front());
                end else begin
                    check(per == W, "R2 word period", per, W);
                end
                e = '0;
                for (int i = 0; i < W; i++)
                    if (bitq.size() > 0) e = {e[W-2:0], bitq.pop_front()};
                check(pdata == e, "R3 R6 word content", int'(pdata), int'(e));
                last_fall = cyc;
            end else if (pdata !== prev_pdata) begin
                check(1'b0, "R4 word changed without fall", int'(pdata), int'(prev_pdata));
            end
        end
        prev_pclk  = pclk;
        prev_pdata = pdata;
    end

    // driver: pushes every driven bit into the scoreboard queue
    task automatic run_bits(input int n, input int hi_at, input int hi_len);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rst   = 1'b0;
            sdata = lfsr[0];
            bitq.push_back(lfsr[0]);
            lfsr  = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
            sync  = (i >= hi_at) && (i < hi_at + hi_len);
            if (i == hi_at) rise_cyc = cyc;
        end
    endtask

    initial begin
        int s0;
        repeat (3) @(negedge clk);
        check(pclk == 1'b0, "R1 reset pclk", int'(pclk), 0);
        check(pdata == '0, "R1 reset word", int'(pdata), 0);
        run_bits(64, -1, 0);
        check(slips == 0, "R2 no slip without sync", slips, 0);
        s0 = slips;
        run_bits(40, 5, 1);
        check(slips == s0, "R5 one-cycle pulse ignored", slips, s0);
        s0 = slips;
        run_bits(40, 5, 2);
        check(slips == s0 + 1, "R6 two-cycle pulse slips once", slips, s0 + 1);
        s0 = slips;
        run_bits(90, 3, 50);
        check(slips == s0 + 1, "R7 long pulse slips once", slips, s0 + 1);
        s0 = slips;
        run_bits(40, 7, 3);
        check(slips == s0 + 1, "R6 three-cycle pulse slips once", slips, s0 + 1);
        run_bits(24, -1, 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            vectors++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule